// File: doc/BRIEF.md
# Dual-Width Parallel ROM Model

This block is a synthesizable behavioural model of a parallel read-only memory. It is meant to sit on a tester's host bus. A 20-bit word address, two active-low controls (chip enable and output enable) and a width-select input choose how the stored 16-bit words are presented.

In wide mode all sixteen data lines carry the addressed word. In narrow mode only the low eight lines carry data. The pin that would otherwise be data bit 15 then becomes an extra least-significant address input, which picks one half of the word. A flag stands in for the raised identification level on an address line. While that flag is set, the block returns two fixed identification codes in place of array data.

Data and per-group output-enable signals are registered, so a result appears one clock after the inputs that select it. The enables cover the low lane, lines 8 to 14 and line 15, so a bench can check the high-impedance state of each group. The array is a small register file that reset fills with a computed pattern.

The mode is held in a state register with five named states:
- `MODE_STANDBY`: chip enable high.
- `MODE_DISABLED`: chip selected, output enable high.
- `MODE_WORD`: wide read.
- `MODE_BYTE`: narrow read.
- `MODE_IDENT`: identification read.

On every clock the state moves to the state that the current inputs select, from any state. Chip enable is decoded first, then output enable, then width-select, then the identification flag.

Top module: `dualwidth_rom`

## Requirements
- R1: During and right after reset the block is in standby. `en_lo`, `en_mid` and `en_top` are low, `dq` is 0x0000 and `low_power` is high.
- R2: With `ce_n`=0, `oe_n`=0, `wide`=1 and `id_level`=0, `dq` carries the full 16-bit word at the address and all three enables are high. `lane_sel` has no effect in this mode.
- R3: With `ce_n`=0, `oe_n`=0, `wide`=0 and `lane_sel`=0, `dq[7:0]` carries bits 7..0 of the word. Only `en_lo` is high and `dq[15:8]` is 0x00.
- R4: With `ce_n`=0, `oe_n`=0, `wide`=0 and `lane_sel`=1, `dq[7:0]` carries bits 15..8 of the word. Only `en_lo` is high and `dq[15:8]` is 0x00.
- R5: With `ce_n`=0 and `oe_n`=1, all three enables are low, `dq` is 0x0000 and `low_power` is low.
- R6: With `ce_n`=1, all three enables are low, `dq` is 0x0000 and `low_power` is high, whatever the value of `oe_n`.
- R7: With `ce_n`=0, `oe_n`=0, `wide`=1 and `id_level`=1, `dq` is 0x0020 when `addr[0]`=0 and 0x00B1 when `addr[0]`=1. All three enables are high.
- R8: `id_level` has no effect in narrow mode: the result is the narrow read of R3 or R4.
- R9: The word at array index i (i = `addr[5:0]`; higher address bits ignored) has high byte (7*i + 0x13) mod 256 and low byte i XOR 0x5A.
- R10: Every output changes only on the clock edge after its inputs are applied. Before that edge the previous result is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the array |
| addr | input | 20 | Word address |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| wide | input | 1 | 1 = 16-bit organisation, 0 = 8-bit organisation |
| lane_sel | input | 1 | Byte-select address in narrow mode (dual-purpose pin) |
| id_level | input | 1 | Stands in for the identification level on the address pin |
| dq | output | 16 | Data lines; 0 where not enabled |
| en_lo | output | 1 | Drive enable for lines 7..0 |
| en_mid | output | 1 | Drive enable for lines 14..8 |
| en_top | output | 1 | Drive enable for line 15 |
| low_power | output | 1 | High while in standby |

## Verification
Every result of this block is due exactly one rising edge after the inputs that select it. This covers data, the three enables and the low-power flag.

The driver changes inputs on the falling edge and enqueues the expected outputs at once. The monitor pops that entry at the next rising edge and compares it 5 ns later, before any new input can take effect.

One extra check samples the outputs 2 ns after an input change, before the rising edge, to show that the previous result is still held.

// File: rtl/rom_pkg.sv
package rom_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_DISABLED,
        MODE_WORD,
        MODE_BYTE,
        MODE_IDENT
    } rom_mode_e;

    localparam logic [7:0] MAKER_CODE = 8'h20;
    localparam logic [7:0] PART_CODE  = 8'hB1;

    // R9: preload pattern for array index idx
    function automatic logic [15:0] preload_word(input int unsigned idx);
        logic [7:0] hi;
        logic [7:0] lo;
        hi = 8'((idx * 7) + 19);
        lo = 8'(idx) ^ 8'h5A;
        return {hi, lo};
    endfunction

endpackage

// File: rtl/rom_mode_fsm.sv
module rom_mode_fsm
    import rom_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      wide,
    input  logic      id_level,
    output rom_mode_e mode_d,
    output rom_mode_e mode_q
);

    // Next state: chip enable first, then output enable, then width, then ID flag
    always_comb begin
        unique casez ({ce_n, oe_n, wide, id_level})
            4'b1???: mode_d = MODE_STANDBY;
            4'b01??: mode_d = MODE_DISABLED;
            4'b0011: mode_d = MODE_IDENT;
            4'b0010: mode_d = MODE_WORD;
            4'b000?: mode_d = MODE_BYTE;
            default: mode_d = MODE_STANDBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_STANDBY;
        end else begin
            mode_q <= mode_d;
        end
    end

    // R6
    standby_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (mode_q == MODE_STANDBY));

    // R8
    narrow_ignores_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !wide && id_level) |=> (mode_q == MODE_BYTE));

endmodule

// File: rtl/rom_array.sv
module rom_array
    import rom_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Reset fills the array; afterwards it is read-only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= DATA_W'(preload_word(i));
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= cells[i];
            end
        end
    end

    assign word = cells[idx];

endmodule

// File: rtl/rom_read_path.sv
module rom_read_path
    import rom_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rom_mode_e         mode_d,
    input  logic [DATA_W-1:0] word,
    input  logic              lane_sel,
    input  logic              code_sel,
    output logic [DATA_W-1:0] dq_q
);

    logic [DATA_W-1:0] dq_d;

    always_comb begin
        unique case (mode_d)
            MODE_STANDBY:  dq_d = '0;
            MODE_DISABLED: dq_d = '0;
            MODE_WORD:     dq_d = word;
            MODE_BYTE:     dq_d = {{HALF_W{1'b0}},
                                   lane_sel ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0]};
            MODE_IDENT:    dq_d = DATA_W'(code_sel ? PART_CODE : MAKER_CODE);
            default:       dq_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_q <= '0;
        end else begin
            dq_q <= dq_d;
        end
    end

    // R3
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_d == MODE_BYTE) |=> (dq_q[DATA_W-1:HALF_W] == '0));

endmodule

// File: rtl/dualwidth_rom.sv
module dualwidth_rom
    import rom_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              wide,
    input  logic              lane_sel,
    input  logic              id_level,
    output logic [DATA_W-1:0] dq,
    output logic              en_lo,
    output logic              en_mid,
    output logic              en_top,
    output logic              low_power
);

    rom_mode_e         mode_d;
    rom_mode_e         mode_q;
    logic [DATA_W-1:0] word;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^addr[ADDR_W-1:IDX_W];

    rom_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .wide     (wide),
        .id_level (id_level),
        .mode_d   (mode_d),
        .mode_q   (mode_q)
    );

    rom_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (addr[IDX_W-1:0]),
        .word  (word)
    );

    rom_read_path #(.DATA_W(DATA_W)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_d   (mode_d),
        .word     (word),
        .lane_sel (lane_sel),
        .code_sel (addr[0]),
        .dq_q     (dq)
    );

    // Output process: lane enables and power flag from the registered state
    always_comb begin
        en_lo     = 1'b0;
        en_mid    = 1'b0;
        en_top    = 1'b0;
        low_power = 1'b0;
        unique case (mode_q)
            MODE_STANDBY:  low_power = 1'b1;
            MODE_DISABLED: ;
            MODE_WORD,
            MODE_IDENT: begin
                en_lo  = 1'b1;
                en_mid = 1'b1;
                en_top = 1'b1;
            end
            MODE_BYTE:     en_lo = 1'b1;
            default:       low_power = 1'b1;
        endcase
    end

    // R6
    standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!en_lo && !en_mid && !en_top && low_power));

    // R5
    disable_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |=> (!en_lo && !en_mid && !en_top && !low_power));

    // R2
    wide_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && wide) |=> (en_lo && en_mid && en_top));

    // R4
    narrow_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !wide) |=> (en_lo && !en_mid && !en_top));

    // R7
    ident_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && wide && id_level) |=> (dq[DATA_W-1:8] == '0 && en_top));

endmodule

// File: tb/dualwidth_rom_test.sv
`timescale 1ns/1ps
module dualwidth_rom_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        wide = 1'b1;
    logic        lane_sel = 1'b0;
    logic        id_level = 1'b0;
    logic [15:0] dq;
    logic        en_lo, en_mid, en_top, low_power;

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic [15:0] dq;
        logic        lo;
        logic        mid;
        logic        top;
        logic        lp;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk;

    dualwidth_rom uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .wide(wide), .lane_sel(lane_sel), .id_level(id_level),
        .dq(dq), .en_lo(en_lo), .en_mid(en_mid), .en_top(en_top),
        .low_power(low_power)
    );

    // R9 pattern, computed from the requirement
    function automatic logic [15:0] model_word(input logic [19:0] a);
        int i;
        i = int'(a[5:0]);
        return {8'((7 * i + 19) % 256), 8'(i ^ 'h5A)};
    endfunction

    function automatic exp_t model(input logic c, input logic o, input logic w,
                                   input logic s, input logic id, input logic [19:0] a);
        exp_t e;
        logic [15:0] wd;
        wd = model_word(a);
        e = '0;
        if (c) begin
            e.lp = 1'b1;
        end else if (o) begin
            e.lp = 1'b0;
        end else if (!w) begin
            e.lo = 1'b1;
            e.dq = {8'h00, s ? wd[15:8] : wd[7:0]};
        end else begin
            e.lo = 1'b1; e.mid = 1'b1; e.top = 1'b1;
            e.dq = id ? (a[0] ? 16'h00B1 : 16'h0020) : wd;
        end
        return e;
    endfunction

    function automatic void compare(input exp_t e, input string tag);
        exp_t got;
        got = '{dq, en_lo, en_mid, en_top, low_power};
        checks++;
        if (got !== e) begin
            fails++;
            $display("FAIL %s: got dq=%h lo=%b mid=%b top=%b lp=%b, expected dq=%h lo=%b mid=%b top=%b lp=%b",
                     tag, got.dq, got.lo, got.mid, got.top, got.lp,
                     e.dq, e.lo, e.mid, e.top, e.lp);
        end
    endfunction

    // Driver: change inputs on the falling edge, enqueue the expected result
    task automatic drive(input logic c, input logic o, input logic w, input logic s,
                         input logic id, input logic [19:0] a, input string tag);
        @(negedge clk);
        ce_n = c; oe_n = o; wide = w; lane_sel = s; id_level = id; addr = a;
        exp_q.push_back(model(c, o, w, s, id, a));
        tag_q.push_back(tag);
    endtask

    // Monitor: result due one rising edge later, sampled 5 ns after it
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                #5;
                compare(e, t);
            end
        end
    end

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        exp_t hold;
        repeat (3) @(negedge clk);
        compare('{16'h0000, 1'b0, 1'b0, 1'b0, 1'b1}, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        compare('{16'h0000, 1'b0, 1'b0, 1'b0, 1'b1}, "R1 after reset release");

        drive(0, 0, 1, 0, 0, 20'h00000, "R2 word read idx 0");
        drive(0, 0, 1, 1, 0, 20'h00005, "R2 word read, lane_sel ignored");
        drive(0, 0, 1, 0, 0, 20'h0003F, "R9 word read idx 63");
        drive(0, 0, 1, 0, 0, 20'hFFFC5, "R9 upper address bits ignored");
        drive(0, 0, 0, 0, 0, 20'h0000A, "R3 narrow low half");
        drive(0, 0, 0, 1, 0, 20'h0000A, "R4 narrow high half");
        drive(0, 0, 0, 1, 0, 20'h00031, "R4 narrow high half idx 49");
        drive(0, 1, 1, 0, 0, 20'h00007, "R5 output disable");
        drive(1, 0, 1, 0, 0, 20'h00007, "R6 standby with oe_n low");
        drive(1, 1, 0, 1, 1, 20'h00007, "R6 standby with oe_n high");
        drive(0, 0, 1, 0, 1, 20'h12340, "R7 ident maker code");
        drive(0, 0, 1, 0, 1, 20'h12341, "R7 ident part code");
        drive(0, 0, 0, 0, 1, 20'h00003, "R8 id flag ignored, narrow low");
        drive(0, 0, 0, 1, 1, 20'h00003, "R8 id flag ignored, narrow high");
        drive(0, 0, 1, 0, 0, 20'h00011, "R10 setup word read");
        repeat (2) @(negedge clk);

        // R10: new inputs must not show before the next rising edge
        hold = model(0, 0, 1, 0, 0, 20'h00011);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; wide = 1'b0; lane_sel = 1'b1; id_level = 1'b0;
        addr = 20'h00022;
        exp_q.push_back(model(0, 0, 0, 1, 0, 20'h00022));
        tag_q.push_back("R10 new result after edge");
        #2;
        compare(hold, "R10 previous result held before edge");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule